// File: doc/BRIEF.md
# Bit-Field Extract Unit with Flags

This block pulls a contiguous field out of a 32-bit or 64-bit operand in one registered step. A control word gives two byte-wide numbers: where the field begins and how many bits it has. The operand is shifted right by the start position, and everything above the requested length is cleared. The result is zero-extended to 64 bits.

With each result the block returns a five-bit condition vector and a parity flag. Only the zero flag carries information. The carry, overflow, sign and auxiliary-carry flags are always cleared. Parity is held at zero, and a configuration input chooses whether that zero is reported as valid or marked undefined.

Out-of-range inputs are handled at the edges. A start beyond the operand's top bit gives zero. A length of zero gives zero. A length at or above the operand width keeps every bit from the start position upward.

Top module: `bfx_unit`

## Requirements
- R1: For a start below the operand width and a length below it, `result` equals (operand >> start) AND ((1 << length) - 1).
- R2: The start is `ctrl[7:0]` and the length is `ctrl[15:8]`. Bits of `ctrl` above bit 15 have no effect on any output.
- R3: When start is greater than the highest bit index of the operand (63 when `size64`=1, 31 when `size64`=0), `result` is zero.
- R4: A length of zero gives a zero `result`.
- R5: A length equal to or greater than the operand width (64 or 32) returns every operand bit from the start position upward, with none dropped.
- R6: When `size64`=0, only `src[31:0]` is used, and `result[63:32]` is zero.
- R7: `flags[0]` (zero flag) is 1 when `result` is zero and 0 otherwise.
- R8: `flags[1]` (carry), `flags[2]` (overflow), `flags[3]` (sign) and `flags[4]` (auxiliary carry) are always 0 after an operation.
- R9: `pf` is always 0 after an operation. `pf_valid` is 1 when `pf_undef_cfg` was 0 at issue, and 0 when it was 1.
- R10: Outputs update on the clock edge at which `in_valid` is high. `out_valid` is high only in the cycle after such an edge. `result`, `flags`, `pf` and `pf_valid` hold while `in_valid` is low.
- R11: After reset, `out_valid`, `result`, `flags`, `pf` and `pf_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| in_valid | input | 1 | Operation strobe |
| size64 | input | 1 | 1 selects a 64-bit operand, 0 selects a 32-bit operand |
| src | input | 64 | Source operand |
| ctrl | input | 64 | Control word: start in [7:0], length in [15:8] |
| pf_undef_cfg | input | 1 | 1 marks parity as undefined, 0 reports parity as a valid zero |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 64 | Extracted field, zero-extended |
| flags | output | 5 | {AF, SF, OF, CF, ZF}, with ZF in bit 0 |
| pf | output | 1 | Parity flag |
| pf_valid | output | 1 | Parity flag is defined |

## Verification
The hardest cases to reach are at the width boundaries. These are a length at or beyond the operand width combined with a nonzero start, and a start just past the top bit in each size. In those cases a naive mask shift would overflow, or a shift would wrap around. The vector table places starts at 31/32, 63/64 and 200, and lengths of 32, 40, 64 and 255, in both sizes. It uses operands whose high halves differ from their low halves, so that a leak of bits 63:32 in 32-bit mode is visible. The table also sets every control bit above 15 in one case, and directed tests cover back-to-back issue and output hold.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int FLAG_W = 5;
  localparam int ZF_BIT = 0;
  localparam int CF_BIT = 1;
  localparam int OF_BIT = 2;
  localparam int SF_BIT = 3;
  localparam int AF_BIT = 4;
endpackage

// File: rtl/bfx_sanitize.sv
module bfx_sanitize #(
  parameter int DATA_W  = 64,
  parameter int HALF_W  = 32,
  parameter int FIELD_W = 8,
  localparam int SH_W   = $clog2(DATA_W)
) (
  input  logic               size64,
  input  logic [FIELD_W-1:0] start_fld,
  input  logic [FIELD_W-1:0] len_fld,
  output logic [SH_W-1:0]    shamt,
  output logic               start_oob,
  output logic               len_full
);
  localparam logic [FIELD_W:0] LIM_WIDE = (FIELD_W+1)'(DATA_W);
  localparam logic [FIELD_W:0] LIM_NARW = (FIELD_W+1)'(HALF_W);

  logic [FIELD_W:0] width_lim;
  logic [FIELD_W:0] start_ext;
  logic [FIELD_W:0] len_ext;

  always_comb begin
    width_lim = size64 ? LIM_WIDE : LIM_NARW;
    start_ext = {1'b0, start_fld};
    len_ext   = {1'b0, len_fld};
    start_oob = (start_ext >= width_lim);
    len_full  = (len_ext >= width_lim);
    shamt     = start_fld[SH_W-1:0];
  end
endmodule

// File: rtl/bfx_shift_mask.sv
module bfx_shift_mask #(
  parameter int DATA_W  = 64,
  parameter int HALF_W  = 32,
  parameter int FIELD_W = 8,
  localparam int SH_W   = $clog2(DATA_W)
) (
  input  logic               size64,
  input  logic [DATA_W-1:0]  src,
  input  logic [SH_W-1:0]    shamt,
  input  logic               start_oob,
  input  logic               len_full,
  input  logic [FIELD_W-1:0] len_fld,
  output logic [DATA_W-1:0]  field
);
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] mask;

  always_comb begin
    operand = size64 ? src : {{(DATA_W-HALF_W){1'b0}}, src[HALF_W-1:0]};
    shifted = operand >> shamt;
  end

  // Thermometer mask, built bit by bit so no shift of 1 ever overflows.
  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    assign mask[b] = len_full | (len_fld > FIELD_W'(b));
  end

  always_comb begin
    field = start_oob ? '0 : (shifted & mask);
  end
endmodule

// File: rtl/bfx_flags.sv
module bfx_flags
  import bfx_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] field,
  input  logic              pf_undef_cfg,
  output logic [FLAG_W-1:0] flag_vec,
  output logic              pf_bit,
  output logic              pf_def
);
  always_comb begin
    flag_vec         = '0;
    flag_vec[ZF_BIT] = (field == '0);
    pf_bit           = 1'b0;
    pf_def           = ~pf_undef_cfg;
  end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int HALF_W  = 32,
  parameter int FIELD_W = 8,
  localparam int SH_W   = $clog2(DATA_W),
  localparam int CTRL_W = 2 * FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              size64,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] ctrl,
  input  logic              pf_undef_cfg,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags,
  output logic              pf,
  output logic              pf_valid
);
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  logic [FIELD_W-1:0] start_fld;
  logic [FIELD_W-1:0] len_fld;
  logic               ctrl_unused;

  assign start_fld   = ctrl[FIELD_W-1:0];
  assign len_fld     = ctrl[CTRL_W-1:FIELD_W];
  assign ctrl_unused = ^ctrl[DATA_W-1:CTRL_W];

  logic [SH_W-1:0]   shamt;
  logic              start_oob;
  logic              len_full;
  logic [DATA_W-1:0] field;
  logic [FLAG_W-1:0] flag_vec;
  logic              pf_bit;
  logic              pf_def;

  bfx_sanitize #(.DATA_W(DATA_W), .HALF_W(HALF_W), .FIELD_W(FIELD_W)) u_sanitize (
    .size64(size64), .start_fld(start_fld), .len_fld(len_fld),
    .shamt(shamt), .start_oob(start_oob), .len_full(len_full)
  );

  bfx_shift_mask #(.DATA_W(DATA_W), .HALF_W(HALF_W), .FIELD_W(FIELD_W)) u_shift_mask (
    .size64(size64), .src(src), .shamt(shamt), .start_oob(start_oob),
    .len_full(len_full), .len_fld(len_fld), .field(field)
  );

  bfx_flags #(.DATA_W(DATA_W)) u_flags (
    .field(field), .pf_undef_cfg(pf_undef_cfg),
    .flag_vec(flag_vec), .pf_bit(pf_bit), .pf_def(pf_def)
  );

  logic              vld_q,   vld_d;
  logic [DATA_W-1:0] res_q,   res_d;
  logic [FLAG_W-1:0] flg_q,   flg_d;
  logic              pf_q,    pf_d;
  logic              pfv_q,   pfv_d;
  logic              data_en;

  always_comb begin
    data_en = in_valid;
    vld_d   = in_valid;
    res_d   = res_q;
    flg_d   = flg_q;
    pf_d    = pf_q;
    pfv_d   = pfv_q;
    if (data_en) begin
      res_d = field;
      flg_d = flag_vec;
      pf_d  = pf_bit;
      pfv_d = pf_def;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      flg_q <= '0;
      pf_q  <= 1'b0;
      pfv_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
      flg_q <= flg_d;
      pf_q  <= pf_d;
      pfv_q <= pfv_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign flags     = flg_q;
  assign pf        = pf_q;
  assign pf_valid  = pfv_q;

  assert_zf_tracks_result_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_valid |-> (flags[ZF_BIT] == (result == '0)));

  assert_other_flags_clear_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_valid |-> (flags[AF_BIT:CF_BIT] == '0));

  assert_start_oob_zero_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_valid && start_oob) |=> (result == '0));

  assert_len_zero_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_valid && (ctrl[CTRL_W-1:FIELD_W] == '0)) |=> (result == '0));

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_valid && !size64) |=> (result[DATA_W-1:HALF_W] == '0));

  assert_parity_cfg_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_valid |=> (!pf && (pf_valid == !$past(pf_undef_cfg))));

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    !in_valid |=> ($stable(result) && $stable(flags) && !out_valid));
endmodule

// File: tb/test_bfx_unit.sv
module test_bfx_unit;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        size64;
  logic [63:0] src;
  logic [63:0] ctrl;
  logic        pf_undef_cfg;
  logic        out_valid;
  logic [63:0] result;
  logic [4:0]  flags;
  logic        pf;
  logic        pf_valid;

  bfx_unit i_bfx_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size64(size64),
    .src(src), .ctrl(ctrl), .pf_undef_cfg(pf_undef_cfg),
    .out_valid(out_valid), .result(result), .flags(flags),
    .pf(pf), .pf_valid(pf_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct packed {
    logic        sz;
    logic [63:0] s;
    logic [63:0] c;
    logic [63:0] e;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0838, 64'h7F},                  // R1
    '{1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0818, 64'hFF},                  // R1 R6
    '{1'b1, 64'h0123_4567_89AB_CDEF, 64'h0404, 64'hE},                   // R1
    '{1'b1, 64'h0123_4567_89AB_CDEF, 64'h1000, 64'hCDEF},                // R1
    '{1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0840, 64'h0},                   // R3
    '{1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0820, 64'h0},                   // R3
    '{1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h081F, 64'h1},                   // R1
    '{1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000, 64'h0},                   // R4
    '{1'b1, 64'h0123_4567_89AB_CDEF, 64'h4008, 64'h0001_2345_6789_ABCD}, // R5
    '{1'b1, 64'h0123_4567_89AB_CDEF, 64'hFF00, 64'h0123_4567_89AB_CDEF}, // R5
    '{1'b0, 64'hDEAD_BEEF_1234_5678, 64'h2804, 64'h0123_4567},           // R5 R6
    '{1'b0, 64'hDEAD_BEEF_1234_5678, 64'h2000, 64'h1234_5678},           // R6
    '{1'b1, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_0404, 64'hE},    // R2
    '{1'b1, 64'h8000_0000_0000_0000, 64'h013F, 64'h1},                   // R1
    '{1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h08C8, 64'h0},                   // R3
    '{1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_0000, 64'h0}     // R4 R2
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic sz, input logic [63:0] s, input logic [63:0] c, input logic cfg);
    @(negedge clk);
    in_valid = 1'b1; size64 = sz; src = s; ctrl = c; pf_undef_cfg = cfg;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_out(input string req, input logic [63:0] exp, input logic cfg);
    check({req, " result"}, result, exp);
    check("R7 zero flag", {63'b0, flags[0]}, {63'b0, exp == 64'h0});
    check("R8 other flags", {60'b0, flags[4:1]}, 64'h0);
    check("R9 parity", {62'b0, pf, pf_valid}, {62'b0, 1'b0, ~cfg});
    check("R10 out_valid", {63'b0, out_valid}, 64'h1);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; size64 = 1'b1; src = '0; ctrl = '0; pf_undef_cfg = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 reset out_valid", {63'b0, out_valid}, 64'h0);
    check("R11 reset result", result, 64'h0);
    check("R11 reset flags pf", {57'b0, flags, pf, pf_valid}, 64'h0);

    for (int k = 0; k < NV; k++) begin
      logic cfg;
      cfg = k[0];
      issue(TBL[k].sz, TBL[k].s, TBL[k].c, cfg);
      check_out($sformatf("R1 vector %0d", k), TBL[k].e, cfg);
    end

    // R10: output holds while idle even as inputs change
    issue(1'b1, 64'h0123_4567_89AB_CDEF, 64'h0808, 1'b1);
    @(negedge clk);
    src = '1; ctrl = 64'h2000; pf_undef_cfg = 1'b0;
    @(negedge clk);
    check("R10 idle out_valid", {63'b0, out_valid}, 64'h0);
    check("R10 hold result", result, 64'hCD);
    check("R10 hold pf_valid", {63'b0, pf_valid}, 64'h0);

    // R10: back-to-back operations
    @(negedge clk);
    in_valid = 1'b1; size64 = 1'b1; src = 64'hF0; ctrl = 64'h0404; pf_undef_cfg = 1'b0;
    @(negedge clk);
    size64 = 1'b0; src = 64'hAAAA_AAAA_5555_5555; ctrl = 64'h2001;
    check("R10 first of pair", result, 64'hF);
    check("R10 first valid", {63'b0, out_valid}, 64'h1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 second of pair", result, 64'h2AAA_AAAA);
    check("R10 second valid", {63'b0, out_valid}, 64'h1);

    // R11: reset in mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 async clear", {62'b0, out_valid, |result}, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule